// File: doc/BRIEF.md
# Shifted-Operand Data-Processing Unit

This block carries out one 32-bit data-processing step each clock. The second operand first passes through a barrel shifter. The shifter supports left, right, arithmetic-right and rotate shifts, plus a one-place rotate through the carry flag. The shifted value then feeds an arithmetic/logic stage with the first operand. The shift amount comes either from a short immediate field or from the low byte of a register value.

Sixteen opcodes cover add and subtract, each with and without carry, reverse subtract, four bitwise operations and two moves. Four probe opcodes (compare and test) update the flags but request no register write.

The result, the write request and the next {N,Z,C,V} flags are registered, so they appear one clock after the inputs. The current flags enter on a port, and the caller feeds the registered flags back when it needs them. The flags change only when the set-flags input is high or the opcode is a probe. Otherwise the incoming flags pass through unchanged.

Top module: `shifted_operand_alu`

## Requirements
- R1: While `rst` is high, and after it, until the first operation is captured, `result` is 0, `wr_en` is 0 and `flags_out` is 0.
- R2: Each operation presented on the inputs at a rising edge appears on `result`, `wr_en` and `flags_out` right after that edge, and a new operation is accepted every cycle.
- R3: `sh_kind` 0 (and the unused codes 5 to 7) is a left shift with zero fill. For an amount n from 1 to 32 the shift carry is the last bit shifted out. Amounts above 32 give 0 with carry 0.
- R4: `sh_kind` 1 is a logical right shift with zero fill and `sh_kind` 2 is an arithmetic right shift with sign fill. The carry is the last bit shifted out. An amount of 32 gives 0 (logical) or all sign bits (arithmetic), with carry equal to bit 31. Above 32, the logical shift gives 0 with carry 0 and the arithmetic shift gives all sign bits with carry equal to the sign.
- R5: `sh_kind` 3 rotates right by the amount modulo 32, and the shift carry is bit 31 of the rotated value. `sh_kind` 4 ignores the amount and shifts right by one place: bit 31 takes the incoming C flag and the carry takes the old bit 0.
- R6: The amount is `sh_imm` when `sh_use_reg` is 0, or bits [7:0] of `sh_reg` when it is 1; the upper bits of `sh_reg` have no effect. An amount of 0 (for `sh_kind` 0 to 3) passes the operand unchanged, and the shift carry is the incoming C.
- R7: Arithmetic opcodes compute their results as follows (b is the shifted operand, C is the incoming carry): 4 gives a+b, 5 gives a+b+C, 2 gives a−b, 6 gives a−b+C−1, 3 gives b−a and 7 gives b−a+C−1.
- R8: Logic opcodes compute their results as follows: 0 gives a AND b, 12 gives a OR b, 1 gives a XOR b, 14 gives a AND NOT b, 13 gives b and 15 gives NOT b.
- R9: Probe opcodes never request a write (`wr_en` = 0) and always update the flags: 10 uses a−b, 11 uses a+b, 8 uses a AND b and 9 uses a XOR b. Every other opcode sets `wr_en` = 1.
- R10: When `set_flags` is 0 and the opcode is not a probe, `flags_out` equals the incoming `flags_in`.
- R11: When the flags update, N is bit 31 and Z is set when the computed value is zero. For arithmetic opcodes, C is the adder carry-out (for subtraction, the inverted borrow) and V is signed overflow.
- R12: When a logic opcode (0, 1, 8, 9, 12 to 15) updates the flags, C takes the shift carry and V keeps its incoming value.

Flag vectors on `flags_in` and `flags_out` are packed as {N,Z,C,V}, with N in bit 3 and V in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, before shifting |
| sh_kind | input | 3 | Shift type code |
| sh_use_reg | input | 1 | 1: amount from `sh_reg`, 0: from `sh_imm` |
| sh_imm | input | 6 | Immediate shift amount |
| sh_reg | input | 32 | Register holding the shift amount in its low byte |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Request a flag update |
| flags_in | input | 4 | Current {N,Z,C,V} |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Registered register-write request |
| flags_out | output | 4 | Registered next {N,Z,C,V} |

## Verification
Every output of this block is due exactly one rising edge after the operation's inputs are applied, including the flags of probe opcodes and the held flags. The driver task computes the expected result, write request and flags from a bit-by-bit shift model and a wide-integer arithmetic model. It stamps each item with the cycle number at which the capturing edge will occur. The monitor compares items only on the falling edge of their stamped cycle, so no check samples a value in the cycle before the register has captured it.

// File: rtl/sopalu_pkg.sv
package sopalu_pkg;

  typedef enum logic [2:0] {
    SH_LEFT  = 3'd0,
    SH_RIGHT = 3'd1,
    SH_ARITH = 3'd2,
    SH_ROT   = 3'd3,
    SH_ROTX  = 3'd4
  } shift_kind_e;

  typedef enum logic [3:0] {
    OP_AND    = 4'd0,
    OP_XOR    = 4'd1,
    OP_SUB    = 4'd2,
    OP_RSUB   = 4'd3,
    OP_ADD    = 4'd4,
    OP_ADDC   = 4'd5,
    OP_SUBC   = 4'd6,
    OP_RSUBC  = 4'd7,
    OP_TSTAND = 4'd8,
    OP_TSTXOR = 4'd9,
    OP_CMPSUB = 4'd10,
    OP_CMPADD = 4'd11,
    OP_OR     = 4'd12,
    OP_PASS   = 4'd13,
    OP_ANDN   = 4'd14,
    OP_PASSN  = 4'd15
  } alu_op_e;

  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;

  function automatic logic is_probe(input logic [3:0] op);
    return op inside {OP_TSTAND, OP_TSTXOR, OP_CMPSUB, OP_CMPADD};
  endfunction

  function automatic logic is_logic(input logic [3:0] op);
    return op inside {OP_AND, OP_XOR, OP_TSTAND, OP_TSTXOR,
                      OP_OR, OP_PASS, OP_ANDN, OP_PASSN};
  endfunction

endpackage

// File: rtl/alu_barrel.sv
module alu_barrel
  import sopalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     din,
  input  logic [2:0]       kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [W-1:0]     dout,
  output logic             cout
);
  // rotation uses the amount modulo W; W is a power of two
  localparam int RW = $clog2(W);

  logic [W:0]        wide_l;
  logic [W:0]        wide_r;
  logic signed [W:0] wide_s;
  logic [RW-1:0]     rot;

  always_comb begin
    rot    = amt[RW-1:0];
    wide_l = {1'b0, din} << amt;
    wide_r = {din, 1'b0} >> amt;
    wide_s = $signed({din, 1'b0}) >>> amt;
    dout   = din;
    cout   = cin;
    if (shift_kind_e'(kind) == SH_ROTX) begin
      dout = {cin, din[W-1:1]};
      cout = din[0];
    end else if (amt != '0) begin
      case (shift_kind_e'(kind))
        SH_RIGHT: begin
          dout = wide_r[W:1];
          cout = wide_r[0];
        end
        SH_ARITH: begin
          dout = wide_s[W:1];
          cout = wide_s[0];
        end
        SH_ROT: begin
          dout = (din >> rot) | (din << (W - int'(rot)));
          cout = dout[W-1];
        end
        default: begin
          dout = wide_l[W-1:0];
          cout = wide_l[W];
        end
      endcase
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import sopalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         sh_c,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] res,
  output logic [3:0]   flags_new,
  output logic         probe
);
  logic [W-1:0] x, y, lres;
  logic         ci, arith;
  logic [W:0]   sum;

  always_comb begin
    x     = a;
    y     = b;
    ci    = 1'b0;
    arith = 1'b1;
    lres  = '0;
    case (alu_op_e'(op))
      OP_ADD, OP_CMPADD: ci = 1'b0;
      OP_ADDC:           ci = flags_in[FL_C];
      OP_SUB, OP_CMPSUB: begin y = ~b; ci = 1'b1;            end
      OP_SUBC:           begin y = ~b; ci = flags_in[FL_C];  end
      OP_RSUB:           begin x = ~a; ci = 1'b1;            end
      OP_RSUBC:          begin x = ~a; ci = flags_in[FL_C];  end
      OP_AND, OP_TSTAND: begin arith = 1'b0; lres = a & b;   end
      OP_XOR, OP_TSTXOR: begin arith = 1'b0; lres = a ^ b;   end
      OP_OR:             begin arith = 1'b0; lres = a | b;   end
      OP_PASS:           begin arith = 1'b0; lres = b;       end
      OP_ANDN:           begin arith = 1'b0; lres = a & ~b;  end
      default:           begin arith = 1'b0; lres = ~b;      end
    endcase
    sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    res = arith ? sum[W-1:0] : lres;
    flags_new[FL_N] = res[W-1];
    flags_new[FL_Z] = (res == '0);
    if (arith) begin
      flags_new[FL_C] = sum[W];
      flags_new[FL_V] = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end else begin
      flags_new[FL_C] = sh_c;
      flags_new[FL_V] = flags_in[FL_V];
    end
    probe = is_probe(op);
  end

endmodule

// File: rtl/shifted_operand_alu.sv
module shifted_operand_alu
  import sopalu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [2:0]       sh_kind,
  input  logic             sh_use_reg,
  input  logic [IMM_W-1:0] sh_imm,
  input  logic [W-1:0]     sh_reg,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic [3:0]       flags_in,
  output logic [W-1:0]     result,
  output logic             wr_en,
  output logic [3:0]       flags_out
);
  localparam int FLAG_W = 4;

  logic [AMT_W-1:0]  amt;
  logic [W-1:0]      b_sh;
  logic              sh_c;
  logic [W-1:0]      alu_res;
  logic [FLAG_W-1:0] alu_fl;
  logic              probe;

  assign amt = sh_use_reg ? sh_reg[AMT_W-1:0] : AMT_W'(sh_imm);

  alu_barrel #(.W(W), .AMT_W(AMT_W)) u_shift (
    .din  (op_b),
    .kind (sh_kind),
    .amt  (amt),
    .cin  (flags_in[FL_C]),
    .dout (b_sh),
    .cout (sh_c)
  );

  alu_core #(.W(W)) u_core (
    .a         (op_a),
    .b         (b_sh),
    .op        (opcode),
    .sh_c      (sh_c),
    .flags_in  (flags_in),
    .res       (alu_res),
    .flags_new (alu_fl),
    .probe     (probe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_en     <= 1'b0;
      flags_out <= '0;
    end else begin
      result    <= alu_res;
      wr_en     <= ~probe;
      flags_out <= (set_flags || probe) ? alu_fl : flags_in;
    end
  end

  AST_PROBE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    is_probe(opcode) |=> !wr_en); // R9

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!set_flags && !is_probe(opcode)) |=> flags_out == $past(flags_in)); // R10

  AST_LOGIC_V_KEPT: assert property (@(posedge clk) disable iff (rst)
    (set_flags && is_logic(opcode)) |=> flags_out[FL_V] == $past(flags_in[FL_V])); // R12

  AST_NZ_TRACK: assert property (@(posedge clk) disable iff (rst)
    (set_flags || is_probe(opcode)) |=>
      (flags_out[FL_Z] == (result == '0)) && (flags_out[FL_N] == result[W-1])); // R11

  AST_ROTX_FILL: assert property (@(posedge clk) disable iff (rst)
    (sh_kind == SH_ROTX && opcode == OP_PASS) |=> result[W-1] == $past(flags_in[FL_C])); // R5

  AST_REG_HIGH_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (sh_use_reg && sh_reg[W-1:AMT_W] != '0 && sh_reg[AMT_W-1:0] == '0 &&
     sh_kind == SH_LEFT && opcode == OP_PASS) |=> result == $past(op_b)); // R6

endmodule

// File: tb/tb_shifted_operand_alu.sv
module tb_shifted_operand_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0, sh_reg = '0;
  logic [2:0]  sh_kind = '0;
  logic        sh_use_reg = 1'b0, set_flags = 1'b0;
  logic [5:0]  sh_imm = '0;
  logic [3:0]  opcode = '0, flags_in = '0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;

  always #2.5 clk = ~clk;

  shifted_operand_alu dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sh_kind(sh_kind),
    .sh_use_reg(sh_use_reg), .sh_imm(sh_imm), .sh_reg(sh_reg),
    .opcode(opcode), .set_flags(set_flags), .flags_in(flags_in),
    .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fl;
    int          due;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // bit-at-a-time shift model
  function automatic void mshift(input logic [31:0] x, input logic [2:0] k,
                                 input int n, input logic ci,
                                 output logic [31:0] o, output logic co);
    o = x; co = ci;
    if (k == 3'd4) begin
      co = x[0]; o = {ci, x[31:1]};
      return;
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        3'd1: begin co = o[0]; o = o >> 1; end
        3'd2: begin co = o[0]; o = {o[31], o[31:1]}; end
        3'd3: begin co = o[0]; o = {o[0], o[31:1]}; end
        default: begin co = o[31]; o = o << 1; end
      endcase
    end
  endfunction

  task automatic go(input logic [31:0] a, input logic [31:0] b, input logic [2:0] k,
                    input logic ureg, input logic [5:0] imm, input logic [31:0] rg,
                    input logic [3:0] op, input logic sf, input logic [3:0] fl,
                    input string tag);
    logic [31:0] bs, r;
    logic        shc, c, v, prb, arith;
    longint      ua, ub, u, sa, sb, s, cc;
    int          n;
    exp_t        e;
    n = ureg ? int'(rg[7:0]) : int'(imm);
    mshift(b, k, n, fl[1], bs, shc);
    ua = longint'(a); ub = longint'(bs);
    sa = longint'($signed(a)); sb = longint'($signed(bs));
    cc = longint'(fl[1]);
    arith = 1'b1; c = 1'b0; v = 1'b0; r = '0;
    prb = (op >= 4'd8 && op <= 4'd11);
    case (op)
      4'd4, 4'd11: begin u = ua + ub;          s = sa + sb;          c = u > 64'hFFFF_FFFF; end
      4'd5:        begin u = ua + ub + cc;     s = sa + sb + cc;     c = u > 64'hFFFF_FFFF; end
      4'd2, 4'd10: begin u = ua - ub;          s = sa - sb;          c = u >= 0; end
      4'd6:        begin u = ua - ub + cc - 1; s = sa - sb + cc - 1; c = u >= 0; end
      4'd3:        begin u = ub - ua;          s = sb - sa;          c = u >= 0; end
      4'd7:        begin u = ub - ua + cc - 1; s = sb - sa + cc - 1; c = u >= 0; end
      default: begin arith = 1'b0; u = 0; s = 0; end
    endcase
    if (arith) begin
      r = u[31:0];
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (op)
        4'd0, 4'd8: r = a & bs;
        4'd1, 4'd9: r = a ^ bs;
        4'd12:      r = a | bs;
        4'd13:      r = bs;
        4'd14:      r = a & ~bs;
        default:    r = ~bs;
      endcase
      c = shc; v = fl[0];
    end
    e.res = r;
    e.wr  = !prb;
    e.fl  = (sf || prb) ? {r[31], r == 0, c, v} : fl;
    e.tag = tag;
    @(negedge clk); #1;
    op_a = a; op_b = b; sh_kind = k; sh_use_reg = ureg; sh_imm = imm;
    sh_reg = rg; opcode = op; set_flags = sf; flags_in = fl;
    e.due = cyc + 1;
    q.push_back(e);
  endtask

  // monitor: compare each item on the falling edge of its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      n_chk++;
      if (result !== q[0].res || wr_en !== q[0].wr || flags_out !== q[0].fl) begin
        n_bad++;
        $display("FAIL %s: got res=%h wr=%b fl=%h, expected res=%h wr=%b fl=%h",
                 q[0].tag, result, wr_en, flags_out, q[0].res, q[0].wr, q[0].fl);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    #(5.0 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: drive busy inputs during reset, outputs must stay cleared
    op_a = 32'hFFFF_FFFF; op_b = 32'h1234_5678; opcode = 4'd4; set_flags = 1'b1; flags_in = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (result !== 32'h0 || wr_en !== 1'b0 || flags_out !== 4'h0) begin
      n_bad++;
      $display("FAIL R1: got res=%h wr=%b fl=%h, expected 0 0 0", result, wr_en, flags_out);
    end
    rst = 1'b0;

    // R2 / R8: plain move, back-to-back operations
    go(32'h0, 32'h1234_5678, 3'd0, 0, 6'd0, 0, 4'd13, 1, 4'h0, "R2");
    go(32'h0, 32'h0BAD_F00D, 3'd0, 0, 6'd0, 0, 4'd13, 0, 4'h5, "R2");
    // R3 left shift
    go(32'h0, 32'hF000_0001, 3'd0, 0, 6'd4,  0,      4'd13, 1, 4'h1, "R3");
    go(32'h0, 32'h0000_0001, 3'd0, 1, 6'd0,  32'd32, 4'd13, 1, 4'h0, "R3");
    go(32'h0, 32'hFFFF_FFFF, 3'd0, 1, 6'd0,  32'd40, 4'd13, 1, 4'h2, "R3");
    go(32'h0, 32'h8000_0001, 3'd6, 0, 6'd1,  0,      4'd13, 1, 4'h0, "R3");
    // R4 right shifts
    go(32'h0, 32'h8000_0000, 3'd1, 0, 6'd32, 0,      4'd13, 1, 4'h0, "R4");
    go(32'h0, 32'h8000_0000, 3'd2, 0, 6'd5,  0,      4'd13, 1, 4'h2, "R4");
    go(32'h0, 32'h8000_0001, 3'd2, 1, 6'd0,  32'd200,4'd13, 1, 4'h0, "R4");
    go(32'h0, 32'h7FFF_FFFF, 3'd2, 1, 6'd0,  32'd32, 4'd13, 1, 4'h2, "R4");
    go(32'h0, 32'hFFFF_FFFF, 3'd1, 1, 6'd0,  32'd33, 4'd13, 1, 4'h2, "R4");
    // R5 rotates
    go(32'h0, 32'h1234_5678, 3'd3, 0, 6'd8,  0,      4'd13, 1, 4'h2, "R5");
    go(32'h0, 32'h8000_0000, 3'd3, 1, 6'd0,  32'd32, 4'd13, 1, 4'h0, "R5");
    go(32'h0, 32'h0000_0003, 3'd4, 0, 6'd7,  0,      4'd13, 1, 4'h2, "R5");
    go(32'h0, 32'h0000_0002, 3'd4, 1, 6'd0,  32'd9,  4'd13, 1, 4'h0, "R5");
    // R6 amount source and zero amount
    go(32'h0, 32'h0000_0011, 3'd0, 1, 6'd2,  32'h0000_0104, 4'd13, 1, 4'h0, "R6");
    go(32'h0, 32'h8000_0001, 3'd1, 1, 6'd3,  32'hABCD_0100, 4'd13, 1, 4'h2, "R6");
    go(32'h0, 32'h8000_0001, 3'd2, 0, 6'd0,  32'h0000_0005, 4'd13, 1, 4'h0, "R6");
    // R7 arithmetic
    go(32'd100, 32'd23, 3'd0, 0, 6'd0, 0, 4'd4, 0, 4'h0, "R7");
    go(32'd100, 32'd23, 3'd0, 0, 6'd0, 0, 4'd5, 0, 4'h2, "R7");
    go(32'd100, 32'd23, 3'd0, 0, 6'd0, 0, 4'd2, 0, 4'h0, "R7");
    go(32'd100, 32'd23, 3'd0, 0, 6'd0, 0, 4'd6, 0, 4'h0, "R7");
    go(32'd100, 32'd23, 3'd0, 0, 6'd0, 0, 4'd3, 1, 4'h0, "R7");
    go(32'd100, 32'd23, 3'd0, 0, 6'd0, 0, 4'd7, 1, 4'h2, "R7");
    go(32'd7,   32'd3,  3'd0, 0, 6'd3, 0, 4'd4, 0, 4'h0, "R7");
    // R8 logic
    go(32'h1111_1111, 32'h0110_0101, 3'd0, 0, 6'd0, 0, 4'd14, 1, 4'h0, "R8");
    go(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'd0, 0, 6'd0, 0, 4'd0,  0, 4'h0, "R8");
    go(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'd0, 0, 6'd0, 0, 4'd12, 0, 4'h0, "R8");
    go(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'd0, 0, 6'd0, 0, 4'd1,  0, 4'h0, "R8");
    go(32'hDEAD_BEEF, 32'h0000_0000, 3'd0, 0, 6'd0, 0, 4'd15, 1, 4'h0, "R8");
    // R9 probes
    go(32'd5, 32'd5, 3'd0, 0, 6'd0, 0, 4'd10, 0, 4'h0, "R9");
    go(32'hFFFF_FFFF, 32'd1, 3'd0, 0, 6'd0, 0, 4'd11, 0, 4'h0, "R9");
    go(32'hFF00_0000, 32'h00FF_0000, 3'd0, 0, 6'd0, 0, 4'd8, 0, 4'h1, "R9");
    go(32'h1234_5678, 32'h1234_5678, 3'd0, 0, 6'd0, 0, 4'd9, 0, 4'h0, "R9");
    // R10 held flags
    go(32'd3, 32'd5, 3'd0, 0, 6'd0, 0, 4'd2, 0, 4'hA, "R10");
    go(32'd0, 32'd0, 3'd0, 0, 6'd0, 0, 4'd0, 0, 4'h5, "R10");
    // R11 arithmetic flags
    go(32'h7FFF_FFFF, 32'd1, 3'd0, 0, 6'd0, 0, 4'd4, 1, 4'h0, "R11");
    go(32'hFFFF_FFFF, 32'd1, 3'd0, 0, 6'd0, 0, 4'd4, 1, 4'h0, "R11");
    go(32'h8000_0000, 32'd1, 3'd0, 0, 6'd0, 0, 4'd2, 1, 4'h0, "R11");
    go(32'd3, 32'd5, 3'd0, 0, 6'd0, 0, 4'd2, 1, 4'h0, "R11");
    go(32'h0, 32'h0, 3'd0, 0, 6'd0, 0, 4'd7, 1, 4'h0, "R11");
    // R12 logic flags
    go(32'hFFFF_FFFF, 32'h8000_0001, 3'd1, 0, 6'd1, 0, 4'd0, 1, 4'h1, "R12");
    go(32'h0, 32'h4000_0000, 3'd0, 0, 6'd2, 0, 4'd12, 1, 4'h0, "R12");

    // mixed operations across all opcodes and shift kinds
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb, rr;
      ra = $urandom(); rb = $urandom(); rr = $urandom();
      if (i % 7 == 0) rr[7:0] = 8'($urandom_range(0, 40));
      go(ra, rb, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
         6'($urandom_range(0, 63)), rr, 4'($urandom_range(0, 15)),
         1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), "R7/R8 mixed");
    end

    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule